// File: doc/BRIEF.md
# ADC Auto-Trigger Start Selector

This block decides the clock cycle in which an analog-to-digital conversion begins. A select field chooses one of several trigger sources: the converter's own conversion-complete flag (free running) or one of the peripheral event lines. The block samples the chosen source every clock. When it sees the source go from low to high, it issues a one-clock start pulse. The pulse is issued only when the converter is enabled, auto-triggering is enabled and no conversion is in progress.

The rising edge is found on the multiplexed signal, not on each source separately. Moving the select from a low source to a high source therefore counts as an edge and starts a conversion. The one exception is a move to the free-running code. That move never starts a conversion, even when the conversion-complete flag is already high. In free-running mode the trigger is masked while a differential channel is selected. Event lines may pass through an optional synchronizer whose depth is a parameter. The block instantiates no converter, no register decoding and no input-buffer control.

Top module: `adc_trig_sel`

## Requirements
- R1: The select code picks the trigger: 0 chooses the conversion-complete flag (free running), and code k from 1 to 7 chooses evt_i[k-1], with bit 0 comparator, 1 external interrupt 0, 2 timer 0 compare A, 3 timer 0 overflow, 4 timer 1 compare B, 5 timer 1 overflow, 6 timer 1 capture. Activity on sources that are not selected has no effect.
- R2: A source that is low in one sampled cycle and high in the next causes start_o to go high for the clock cycle that follows the first high sample.
- R3: No start is issued while conv_en_i is low.
- R4: No start is issued while auto_en_i is low.
- R5: An edge sampled while conv_busy_i is high is dropped and not replayed later.
- R6: Changing the select from a source that is low to a source that is high produces a start.
- R7: Changing the select to code 0 never produces a start, even if conv_done_i is already high.
- R8: In free-running mode, diff_chan_i high blocks every start. Under a nonzero select, diff_chan_i has no effect.
- R9: In free-running mode, each rising edge of conv_done_i produces a start.
- R10: start_o is never high for two consecutive cycles.
- R11: During reset and in the first cycle after it, start_o is low. The stored select is 0 and the stored trigger sample is 0.
- R12: A source held high produces only one start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_en_i | input | 1 | Converter enable |
| auto_en_i | input | 1 | Auto-trigger enable |
| src_sel_i | input | SEL_W (3) | Trigger source select |
| evt_i | input | NUM_EVT (7) | Peripheral event lines |
| conv_done_i | input | 1 | Conversion-complete flag |
| conv_busy_i | input | 1 | Conversion in progress |
| diff_chan_i | input | 1 | Differential channel selected |
| start_o | output | 1 | One-clock start-conversion pulse |

## Verification
The bench builds the block with NUM_EVT = 7 and SYNC_STAGES = 0. These are the default values, so every select code maps to a real event line. With no synchronizer in the path, a start appears exactly one clock after the edge is sampled. At that fixed latency the bench can check, cycle by cycle, the edges caused by select changes, the quiet move into free running and the masking by the enables, busy and the differential-channel input.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
   localparam int unsigned TRIG_SEL_W = 3;
   typedef enum logic [TRIG_SEL_W-1:0] {
      SRC_FREE    = 3'd0,
      SRC_ACOMP   = 3'd1,
      SRC_EXT0    = 3'd2,
      SRC_T0_CMPA = 3'd3,
      SRC_T0_OVF  = 3'd4,
      SRC_T1_CMPB = 3'd5,
      SRC_T1_OVF  = 3'd6,
      SRC_T1_CAPT = 3'd7
   } trig_src_e;
   localparam int unsigned FREE_CODE = 0;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
   parameter int unsigned WIDTH  = 7,
   parameter int unsigned STAGES = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial begin
      assert (STAGES <= 4) else $error("evt_sync: STAGES above 4");
      assert (WIDTH >= 1)  else $error("evt_sync: WIDTH must be positive");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            end else begin
               stage_q[0] <= d_i;
               for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            end
         end
         assign q_o = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/trig_mux.sv
module trig_mux #(
   parameter int unsigned NUM_EVT = 7,
   parameter int unsigned SEL_W   = 3
) (
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               done_i,
   input  logic               diff_i,
   output logic               trig_o
);
   initial begin
      assert (NUM_EVT + 1 <= (1 << SEL_W)) else $error("trig_mux: select too narrow");
   end

   always_comb begin
      trig_o = 1'b0;
      if (sel_i == SEL_W'(adc_trig_pkg::FREE_CODE)) trig_o = done_i & ~diff_i;
      for (int k = 0; k < NUM_EVT; k++) begin
         if (sel_i == SEL_W'(k + 1)) trig_o = evt_i[k];
      end
   end
endmodule

// File: rtl/trig_edge.sv
module trig_edge #(
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             trig_i,
   output logic             rise_o
);
   localparam logic [SEL_W-1:0] FREE = SEL_W'(adc_trig_pkg::FREE_CODE);

   logic [SEL_W-1:0] sel_q;
   logic             prev_q;
   logic             enter_free;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q  <= FREE;
         prev_q <= 1'b0;
      end else begin
         sel_q  <= sel_i;
         prev_q <= trig_i;
      end
   end

   assign enter_free = (sel_i == FREE) && (sel_q != FREE);
   assign rise_o     = trig_i & ~prev_q & ~enter_free;

   p_free_entry_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == FREE && $past(sel_i) != FREE) |-> !rise_o);
   p_held_no_rise_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(trig_i) && trig_i) |-> !rise_o);
endmodule

// File: rtl/start_gate.sv
module start_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rise_i,
   input  logic conv_en_i,
   input  logic auto_en_i,
   input  logic busy_i,
   output logic start_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) start_o <= 1'b0;
      else         start_o <= rise_i & conv_en_i & auto_en_i & ~busy_i;
   end

   p_pulse_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o |=> !start_o);
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
   parameter int unsigned NUM_EVT     = 7,
   parameter int unsigned SYNC_STAGES = 0,
   localparam int unsigned SEL_W      = $clog2(NUM_EVT + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               conv_en_i,
   input  logic               auto_en_i,
   input  logic [SEL_W-1:0]   src_sel_i,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               conv_done_i,
   input  logic               conv_busy_i,
   input  logic               diff_chan_i,
   output logic               start_o
);
   localparam logic [SEL_W-1:0] FREE = SEL_W'(adc_trig_pkg::FREE_CODE);

   initial begin
      assert (NUM_EVT >= 1) else $error("adc_trig_sel: need at least one event line");
   end

   logic [NUM_EVT-1:0] evt_s;
   logic               trig;
   logic               rise;

   evt_sync #(.WIDTH(NUM_EVT), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i), .rst_ni(rst_ni), .d_i(evt_i), .q_o(evt_s)
   );

   trig_mux #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_mux (
      .sel_i (src_sel_i), .evt_i(evt_s), .done_i(conv_done_i),
      .diff_i(diff_chan_i), .trig_o(trig)
   );

   trig_edge #(.SEL_W(SEL_W)) u_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(src_sel_i),
      .trig_i(trig), .rise_o(rise)
   );

   start_gate u_gate (
      .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise),
      .conv_en_i(conv_en_i), .auto_en_i(auto_en_i),
      .busy_i(conv_busy_i), .start_o(start_o)
   );

   p_need_conv_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !conv_en_i |=> !start_o);
   p_need_auto_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !auto_en_i |=> !start_o);
   p_busy_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_busy_i |=> !start_o);
   p_diff_blocks_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_sel_i == FREE && diff_chan_i) |=> !start_o);
   p_free_switch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_sel_i == FREE && $past(src_sel_i) != FREE) |=> !start_o);
endmodule

// File: tb/adc_trig_sel_bench.sv
module adc_trig_sel_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conv_en = 1'b1, auto_en = 1'b1, busy = 1'b0, diff = 1'b0, done = 1'b0;
   logic [2:0] sel = 3'd0;
   logic [6:0] evt = 7'd0;
   logic       start;

   int unsigned n_chk = 0, n_fail = 0;

   typedef struct { bit exp; string tag; } item_t;
   item_t q[$];

   always #2 clk = ~clk;

   adc_trig_sel u_adc_trig_sel (
      .clk_i(clk), .rst_ni(rst_n), .conv_en_i(conv_en), .auto_en_i(auto_en),
      .src_sel_i(sel), .evt_i(evt), .conv_done_i(done), .conv_busy_i(busy),
      .diff_chan_i(diff), .start_o(start)
   );

   task automatic check(input bit exp, input string tag);
      n_chk++;
      if (start !== exp) begin
         n_fail++;
         $display("FAIL %s: start_o=%b expected %b at %0t", tag, start, exp, $time);
      end
   endtask

   // driver: inputs are already applied at this negedge; expectation is for after next posedge
   task automatic tick(input bit exp, input string tag);
      item_t it;
      it.exp = exp; it.tag = tag;
      q.push_back(it);
      @(negedge clk);
   endtask

   // monitor
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         check(it.exp, it.tag);
      end
   end

   initial begin
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: start_o=%b expected finish", start);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(1'b0, "R11 in reset");
      rst_n = 1'b1;
      tick(1'b0, "R11 after reset");

      // R6: switch to a low source, no start
      sel = 3'd1; tick(1'b0, "R6 low target");
      evt[0] = 1'b1; tick(1'b1, "R2 rising edge");
      tick(1'b0, "R10 single pulse");
      tick(1'b0, "R12 held high");
      evt = 7'd0; tick(1'b0, "R2 falling");
      evt[1] = 1'b1; tick(1'b0, "R1 unselected line");
      sel = 3'd2; tick(1'b1, "R6 switch to high source");
      tick(1'b0, "R10 after switch");

      // R1: walk every code
      for (int k = 1; k <= 7; k++) begin
         evt = 7'd0; sel = 3'(k); tick(1'b0, "R1 setup");
         evt = ~(7'd1 << (k - 1)); tick(1'b0, "R1 others high");
         evt = 7'h7f; tick(1'b1, "R1 selected rise");
         tick(1'b0, "R12 held");
      end

      // R3
      evt = 7'd0; sel = 3'd3; tick(1'b0, "R3 setup");
      conv_en = 1'b0; evt[2] = 1'b1; tick(1'b0, "R3 disabled");
      tick(1'b0, "R3 disabled hold");
      evt = 7'd0; conv_en = 1'b1; tick(1'b0, "R3 restore");

      // R4
      auto_en = 1'b0; evt[2] = 1'b1; tick(1'b0, "R4 auto off");
      evt = 7'd0; tick(1'b0, "R4 setup");
      auto_en = 1'b1; tick(1'b0, "R4 restore");

      // R5
      busy = 1'b1; evt[2] = 1'b1; tick(1'b0, "R5 busy edge");
      busy = 1'b0; tick(1'b0, "R5 not replayed");
      evt = 7'd0; tick(1'b0, "R5 clear");

      // R7: into free running with done high
      sel = 3'd5; done = 1'b1; tick(1'b0, "R7 setup");
      sel = 3'd0; tick(1'b0, "R7 switch from low");
      tick(1'b0, "R7 stay");
      sel = 3'd5; tick(1'b0, "R7 leave");
      evt[4] = 1'b1; tick(1'b1, "R2 t1 compare B");
      sel = 3'd0; tick(1'b0, "R7 switch from high");
      tick(1'b0, "R7 stay high");

      // R9
      done = 1'b0; tick(1'b0, "R9 clear");
      done = 1'b1; tick(1'b1, "R9 first");
      tick(1'b0, "R9 held");
      done = 1'b0; tick(1'b0, "R9 clear again");
      done = 1'b1; tick(1'b1, "R9 second");
      done = 1'b0; tick(1'b0, "R9 drop");

      // R8
      diff = 1'b1; tick(1'b0, "R8 setup");
      done = 1'b1; tick(1'b0, "R8 blocked");
      tick(1'b0, "R8 blocked hold");
      done = 1'b0; tick(1'b0, "R8 clear");
      evt = 7'd0; sel = 3'd6; tick(1'b0, "R8 other source");
      evt[5] = 1'b1; tick(1'b1, "R8 diff ignored off free run");
      diff = 1'b0; evt = 7'd0; tick(1'b0, "R8 end");

      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule